// File: doc/BRIEF.md
# Retention Save and Restore Sequencer

This block moves a fixed set of configuration words between the main register file and a retention store that stays powered while the rest of the device sleeps. A sleep request starts a save. The block walks the word list, one word per cycle, from register-file slot i into retention slot i. It then pads with idle cycles until a parameterised copy window has elapsed, so that every copy takes the same time. At the end of the save it raises `asleep`, which tells the power controller it may remove power.

On a wake event the block restores the words from retention into the register file, but only if the restore enable is set. After the restore, it copies a regulator trim value from one-time-programmable memory into the regulator tuning register, but only if the trim-load enable is set. When the restore is disabled, the trim load follows the wake directly. A one-cycle `wake_done` pulse closes the wake sequence.

While any copy is running, `busy` is high. During that time, host requests to the general registers and to the OTP are held without a grant. Requests to the data buffers are always granted. A sleep request that arrives during the wake sequence is remembered, and the save starts as soon as the wake sequence ends.

Top module: `aon_cfg_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `asleep`, `wake_done` and all memory write enables are 0.
- R2: A `sleep_req` while idle copies register-file slot i to retention slot i for every i below NUM_WORDS. `busy` stays high for exactly COPY_CYCLES cycles, after which `asleep` rises.
- R3: While `asleep` is high, the retention store is never written.
- R4: A `wake_evt` while asleep with `restore_en`=1 writes retention slot i back to register-file slot i for every word, with `busy` high for COPY_CYCLES cycles. All register-file writes fall inside busy cycles.
- R5: With `restore_en`=0 at wake, the register file is not written.
- R6: With `ldo_load_en`=1 at wake, one cycle reads `otp_rdata` and writes it to the trim register through `ldo_wr_en`/`ldo_trim`. That cycle comes after the restore, or right after wake if the restore is off, and it counts as one busy cycle. `ldo_wr_en` is never high for two cycles in a row.
- R7: With `ldo_load_en`=0 at wake, the trim register is not written.
- R8: While `busy` is high, `host_gen_gnt` is 0. A request held through the copy is granted in the first cycle `busy` is low.
- R9: `host_buf_gnt` equals `host_buf_req` in every cycle, including during copies.
- R10: A `sleep_req` during the restore or trim load is kept. A save begins in the cycle after `wake_done`, without a further request.
- R11: `wake_done` is a single-cycle pulse that ends each wake sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to save and sleep |
| wake_evt | input | 1 | One-cycle wake event |
| restore_en | input | 1 | Restore the configuration on wake |
| ldo_load_en | input | 1 | Load the regulator trim from OTP on wake |
| rf_addr | output | clog2(NUM_WORDS) | Register-file word address |
| rf_rd_en | output | 1 | Register-file read strobe |
| rf_rdata | input | WORD_W | Register-file read data (same-cycle) |
| rf_wr_en | output | 1 | Register-file write strobe |
| rf_wdata | output | WORD_W | Register-file write data |
| ret_addr | output | clog2(NUM_WORDS) | Retention store word address |
| ret_rd_en | output | 1 | Retention read strobe |
| ret_rdata | input | WORD_W | Retention read data (same-cycle) |
| ret_wr_en | output | 1 | Retention write strobe |
| ret_wdata | output | WORD_W | Retention write data |
| otp_rd_en | output | 1 | OTP trim word read strobe |
| otp_rdata | input | TRIM_W | OTP trim word |
| ldo_wr_en | output | 1 | Trim register write strobe |
| ldo_trim | output | TRIM_W | Trim register write data |
| host_gen_req | input | 1 | Host request to general registers or OTP |
| host_gen_gnt | output | 1 | Grant for the general request |
| host_buf_req | input | 1 | Host request to the data buffers |
| host_buf_gnt | output | 1 | Grant for the buffer request |
| busy | output | 1 | A copy or trim load is in progress |
| asleep | output | 1 | Save complete; power may be removed |
| wake_done | output | 1 | One-cycle pulse at the end of a wake sequence |

## Verification
The save and restore path is exercised with four word patterns: all zeros, all ones, random words, and the bitwise inverse written into the register file while asleep. The inverse pattern distinguishes a real restore from a register file that was simply left untouched. All four combinations of the two wake enables are run directly, and further random combinations follow. These runs separate a missing restore, a stray restore, a missing trim load and a wrong busy length. A sleep request raised in the middle of a restore shows whether the save is deferred or lost. A general request held through the whole wake sequence, together with random buffer requests, separates stalling from dropping and checks the buffer grant on its own.

// File: rtl/aon_seq_pkg.sv
// Package: shared state encoding for the retention sequencer.
// Assumes: nothing; it holds only types.
package aon_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SAVE     = 3'd1,
        ST_SLEEPING = 3'd2,
        ST_RESTORE  = 3'd3,
        ST_LDO_LOAD = 3'd4,
        ST_DONE     = 3'd5
    } aon_state_e;

endpackage

// File: rtl/aon_copy_timer.sv
// Module: copy window counter.
// It counts the cycles of one save or restore window. It flags the cycles
// that carry a word and the last cycle of the window.
// Assumes: COPY_CYCLES >= NUM_WORDS >= 2. The run input stays high for the
// whole window and drops afterwards.
module aon_copy_timer #(
    parameter int NUM_WORDS   = 8,
    parameter int COPY_CYCLES = 24,
    parameter int CNT_W       = $clog2(COPY_CYCLES),
    parameter int ADDR_W      = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [ADDR_W-1:0] word_addr,
    output logic              word_act,
    output logic              last
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(COPY_CYCLES - 1);
    localparam logic [CNT_W:0]   WORD_LIM = (CNT_W + 1)'(NUM_WORDS);

    logic [CNT_W-1:0] cnt_q;

    // Window position: advances while running, wraps at the end, parks at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // Decode the word slot and the end of the window.
    always_comb begin
        last      = run && (cnt_q == LAST_IDX);
        word_act  = run && ({1'b0, cnt_q} < WORD_LIM);
        word_addr = cnt_q[ADDR_W-1:0];
    end

endmodule

// File: rtl/aon_seq_fsm.sv
// Module: sleep and wake sequencing state machine.
// It steps through save, sleep, restore, trim load and done. It keeps a
// sleep request that arrives during the wake sequence and replays it.
// Assumes: sleep_req and wake_evt are single-cycle events, and the enables
// hold steady from wake until the end of the wake sequence.
module aon_seq_fsm
    import aon_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_evt,
    input  logic       restore_en,
    input  logic       ldo_load_en,
    input  logic       copy_last,
    output aon_state_e state
);

    aon_state_e state_q;
    aon_state_e state_d;
    logic       save_pend_q;

    // Next-state choice for each phase of the sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_req || save_pend_q) state_d = ST_SAVE;
            end
            ST_SAVE: begin
                if (copy_last) state_d = ST_SLEEPING;
            end
            ST_SLEEPING: begin
                if (wake_evt) begin
                    if (restore_en)       state_d = ST_RESTORE;
                    else if (ldo_load_en) state_d = ST_LDO_LOAD;
                    else                  state_d = ST_DONE;
                end
            end
            ST_RESTORE: begin
                if (copy_last) state_d = ldo_load_en ? ST_LDO_LOAD : ST_DONE;
            end
            ST_LDO_LOAD: begin
                state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = (sleep_req || save_pend_q) ? ST_SAVE : ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Deferred save: set by a sleep request during the wake copy, cleared when a save starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_pend_q <= 1'b0;
        end else if (state_d == ST_SAVE) begin
            save_pend_q <= 1'b0;
        end else if (sleep_req &&
                     (state_q == ST_RESTORE || state_q == ST_LDO_LOAD)) begin
            save_pend_q <= 1'b1;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/aon_seq_datapath.sv
// Module: memory port steering and host gating.
// It drives the register file, retention, OTP and trim ports for the current
// state, and it derives the busy, sleep and grant outputs.
// Assumes: register-file and retention reads return data in the same cycle.
module aon_seq_datapath
    import aon_seq_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int TRIM_W = 8,
    parameter int ADDR_W = 3
) (
    input  aon_state_e        state,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic              word_act,
    input  logic [WORD_W-1:0] rf_rdata,
    input  logic [WORD_W-1:0] ret_rdata,
    input  logic [TRIM_W-1:0] otp_rdata,
    input  logic              host_gen_req,
    input  logic              host_buf_req,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_rd_en,
    output logic              rf_wr_en,
    output logic [WORD_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              ret_rd_en,
    output logic              ret_wr_en,
    output logic [WORD_W-1:0] ret_wdata,
    output logic              otp_rd_en,
    output logic              ldo_wr_en,
    output logic [TRIM_W-1:0] ldo_trim,
    output logic              host_gen_gnt,
    output logic              host_buf_gnt,
    output logic              busy,
    output logic              asleep,
    output logic              wake_done
);

    logic saving;
    logic restoring;
    logic trimming;

    // Phase decode shared by the port and gating logic.
    always_comb begin
        saving    = (state == ST_SAVE);
        restoring = (state == ST_RESTORE);
        trimming  = (state == ST_LDO_LOAD);
    end

    // Word movement: register file into retention on save, back on restore.
    always_comb begin
        rf_addr   = word_addr;
        ret_addr  = word_addr;
        rf_rd_en  = saving && word_act;
        ret_wr_en = saving && word_act;
        ret_wdata = rf_rdata;
        ret_rd_en = restoring && word_act;
        rf_wr_en  = restoring && word_act;
        rf_wdata  = ret_rdata;
    end

    // Trim transfer from OTP to the regulator tuning register.
    always_comb begin
        otp_rd_en = trimming;
        ldo_wr_en = trimming;
        ldo_trim  = otp_rdata;
    end

    // Status flags and host access gating.
    always_comb begin
        busy         = saving || restoring || trimming;
        asleep       = (state == ST_SLEEPING);
        wake_done    = (state == ST_DONE);
        host_gen_gnt = host_gen_req && !busy;
        host_buf_gnt = host_buf_req;
    end

endmodule

// File: rtl/aon_cfg_sequencer.sv
// Module: top of the retention save and restore sequencer.
// It connects the copy window counter, the sequencing state machine and the
// port steering.
// Assumes: COPY_CYCLES >= NUM_WORDS >= 2. Memory reads are combinational.
// The power switch is handled elsewhere.
module aon_cfg_sequencer
    import aon_seq_pkg::*;
#(
    parameter int NUM_WORDS   = 8,
    parameter int WORD_W      = 16,
    parameter int TRIM_W      = 8,
    parameter int COPY_CYCLES = 24
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sleep_req,
    input  logic                         wake_evt,
    input  logic                         restore_en,
    input  logic                         ldo_load_en,
    output logic [$clog2(NUM_WORDS)-1:0] rf_addr,
    output logic                         rf_rd_en,
    input  logic [WORD_W-1:0]            rf_rdata,
    output logic                         rf_wr_en,
    output logic [WORD_W-1:0]            rf_wdata,
    output logic [$clog2(NUM_WORDS)-1:0] ret_addr,
    output logic                         ret_rd_en,
    input  logic [WORD_W-1:0]            ret_rdata,
    output logic                         ret_wr_en,
    output logic [WORD_W-1:0]            ret_wdata,
    output logic                         otp_rd_en,
    input  logic [TRIM_W-1:0]            otp_rdata,
    output logic                         ldo_wr_en,
    output logic [TRIM_W-1:0]            ldo_trim,
    input  logic                         host_gen_req,
    output logic                         host_gen_gnt,
    input  logic                         host_buf_req,
    output logic                         host_buf_gnt,
    output logic                         busy,
    output logic                         asleep,
    output logic                         wake_done
);

    localparam int ADDR_W = $clog2(NUM_WORDS);
    localparam int CNT_W  = $clog2(COPY_CYCLES);

    aon_state_e        state;
    logic              copy_run;
    logic              copy_last;
    logic              word_act;
    logic [ADDR_W-1:0] word_addr;

    // The window counter runs only in the two copy phases.
    assign copy_run = (state == ST_SAVE) || (state == ST_RESTORE);

    aon_copy_timer #(
        .NUM_WORDS   (NUM_WORDS),
        .COPY_CYCLES (COPY_CYCLES),
        .CNT_W       (CNT_W),
        .ADDR_W      (ADDR_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (copy_run),
        .word_addr (word_addr),
        .word_act  (word_act),
        .last      (copy_last)
    );

    aon_seq_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_req   (sleep_req),
        .wake_evt    (wake_evt),
        .restore_en  (restore_en),
        .ldo_load_en (ldo_load_en),
        .copy_last   (copy_last),
        .state       (state)
    );

    aon_seq_datapath #(
        .WORD_W (WORD_W),
        .TRIM_W (TRIM_W),
        .ADDR_W (ADDR_W)
    ) dp_i (
        .state        (state),
        .word_addr    (word_addr),
        .word_act     (word_act),
        .rf_rdata     (rf_rdata),
        .ret_rdata    (ret_rdata),
        .otp_rdata    (otp_rdata),
        .host_gen_req (host_gen_req),
        .host_buf_req (host_buf_req),
        .rf_addr      (rf_addr),
        .rf_rd_en     (rf_rd_en),
        .rf_wr_en     (rf_wr_en),
        .rf_wdata     (rf_wdata),
        .ret_addr     (ret_addr),
        .ret_rd_en    (ret_rd_en),
        .ret_wr_en    (ret_wr_en),
        .ret_wdata    (ret_wdata),
        .otp_rd_en    (otp_rd_en),
        .ldo_wr_en    (ldo_wr_en),
        .ldo_trim     (ldo_trim),
        .host_gen_gnt (host_gen_gnt),
        .host_buf_gnt (host_buf_gnt),
        .busy         (busy),
        .asleep       (asleep),
        .wake_done    (wake_done)
    );

endmodule

// File: rtl/aon_cfg_sequencer_chk.sv
// Module: property checker for the sequencer. It is bound to the top module
// and watches only the top-level ports.
// Assumes: synchronous active-low reset is asserted at the first clock edge.
module aon_cfg_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic asleep,
    input logic wake_done,
    input logic rf_wr_en,
    input logic ret_wr_en,
    input logic ldo_wr_en,
    input logic host_gen_gnt,
    input logic host_buf_req,
    input logic host_buf_gnt
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !asleep && !wake_done && !rf_wr_en && !ret_wr_en));

    assert_save_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ret_wr_en |-> (busy && !rf_wr_en));

    assert_sleep_after_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(busy));

    assert_no_ret_write_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !ret_wr_en);

    assert_restore_in_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (busy && !asleep));

    assert_trim_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ldo_wr_en |=> !ldo_wr_en);

    assert_no_gnt_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !host_gen_gnt);

    assert_buf_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_buf_gnt == host_buf_req);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

endmodule

bind aon_cfg_sequencer aon_cfg_sequencer_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .asleep       (asleep),
    .wake_done    (wake_done),
    .rf_wr_en     (rf_wr_en),
    .ret_wr_en    (ret_wr_en),
    .ldo_wr_en    (ldo_wr_en),
    .host_gen_gnt (host_gen_gnt),
    .host_buf_req (host_buf_req),
    .host_buf_gnt (host_buf_gnt)
);

// File: tb/aon_cfg_sequencer_tb_top.sv
// Bench: models the register file, the retention store, the OTP and the trim
// register around the sequencer. Directed and random save/wake cycles are
// checked against values the bench computes itself.
module aon_cfg_sequencer_tb_top;

    localparam int CLK_PERIOD  = 10;
    localparam int NUM_WORDS   = 8;
    localparam int WORD_W      = 16;
    localparam int TRIM_W      = 8;
    localparam int COPY_CYCLES = 24;
    localparam int ADDR_W      = $clog2(NUM_WORDS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic wake_evt = 1'b0;
    logic restore_en = 1'b0;
    logic ldo_load_en = 1'b0;
    logic host_gen_req = 1'b0;
    logic host_buf_req = 1'b0;
    logic [ADDR_W-1:0] rf_addr, ret_addr;
    logic rf_rd_en, rf_wr_en, ret_rd_en, ret_wr_en, otp_rd_en, ldo_wr_en;
    logic [WORD_W-1:0] rf_rdata, rf_wdata, ret_rdata, ret_wdata;
    logic [TRIM_W-1:0] otp_rdata, ldo_trim;
    logic host_gen_gnt, host_buf_gnt, busy, asleep, wake_done;

    // Memory models and bench write port.
    logic [WORD_W-1:0] rf_mem  [NUM_WORDS];
    logic [WORD_W-1:0] ret_mem [NUM_WORDS];
    logic [WORD_W-1:0] snap    [NUM_WORDS];
    logic [TRIM_W-1:0] ldo_reg = '0;
    logic [TRIM_W-1:0] otp_val = '0;
    logic              tb_we = 1'b0;
    logic [ADDR_W-1:0] tb_idx = '0;
    logic [WORD_W-1:0] tb_val = '0;

    int n_checks = 0;
    int n_errors = 0;
    int viol_gnt = 0;
    int viol_buf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    aon_cfg_sequencer #(
        .NUM_WORDS   (NUM_WORDS),
        .WORD_W      (WORD_W),
        .TRIM_W      (TRIM_W),
        .COPY_CYCLES (COPY_CYCLES)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .sleep_req (sleep_req), .wake_evt (wake_evt),
        .restore_en (restore_en), .ldo_load_en (ldo_load_en),
        .rf_addr (rf_addr), .rf_rd_en (rf_rd_en), .rf_rdata (rf_rdata),
        .rf_wr_en (rf_wr_en), .rf_wdata (rf_wdata),
        .ret_addr (ret_addr), .ret_rd_en (ret_rd_en), .ret_rdata (ret_rdata),
        .ret_wr_en (ret_wr_en), .ret_wdata (ret_wdata),
        .otp_rd_en (otp_rd_en), .otp_rdata (otp_rdata),
        .ldo_wr_en (ldo_wr_en), .ldo_trim (ldo_trim),
        .host_gen_req (host_gen_req), .host_gen_gnt (host_gen_gnt),
        .host_buf_req (host_buf_req), .host_buf_gnt (host_buf_gnt),
        .busy (busy), .asleep (asleep), .wake_done (wake_done)
    );

    assign rf_rdata  = rf_mem[rf_addr];
    assign ret_rdata = ret_mem[ret_addr];
    assign otp_rdata = otp_val;

    // Memory write side: design writes first, bench preload otherwise.
    always @(posedge clk) begin
        if (rf_wr_en)   rf_mem[rf_addr] <= rf_wdata;
        else if (tb_we) rf_mem[tb_idx]  <= tb_val;
        if (ret_wr_en)  ret_mem[ret_addr] <= ret_wdata;
        if (ldo_wr_en)  ldo_reg <= ldo_trim;
    end

    // Random buffer requests, changed just after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1 host_buf_req = 1'($urandom % 2);
        end
    end

    // Per-cycle monitors for grant rules (R8, R9).
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && host_gen_gnt) viol_gnt++;
            if (host_buf_gnt != host_buf_req) viol_buf++;
        end
    end

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    function automatic logic [WORD_W-1:0] pattern_word(input int mode);
        case (mode)
            0:       return '0;
            1:       return '1;
            default: return WORD_W'($urandom);
        endcase
    endfunction

    // Preload every register-file word through the bench port.
    task automatic load_rf(input int mode, input bit invert);
        for (int i = 0; i < NUM_WORDS; i++) begin
            @(negedge clk);
            tb_we  = 1'b1;
            tb_idx = ADDR_W'(i);
            if (invert) begin
                tb_val = ~snap[i];
            end else begin
                snap[i] = pattern_word(mode);
                tb_val  = snap[i];
            end
        end
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic int count_mismatch(input bit use_ret, input bit invert);
        int bad = 0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            logic [WORD_W-1:0] exp_w;
            logic [WORD_W-1:0] act_w;
            exp_w = invert ? ~snap[i] : snap[i];
            act_w = use_ret ? ret_mem[i] : rf_mem[i];
            if (act_w != exp_w) bad++;
        end
        return bad;
    endfunction

    // Save phase: request sleep, count busy cycles until asleep (R2, R3).
    task automatic do_save(input string tag);
        int busy_n = 0;
        @(negedge clk) sleep_req = 1'b1;
        @(negedge clk) sleep_req = 1'b0;
        while (!asleep) begin
            if (busy) busy_n++;
            @(negedge clk);
        end
        check_eq("R2", {tag, " save busy cycles"}, busy_n, COPY_CYCLES);
        check_eq("R2", {tag, " retention mismatches"}, count_mismatch(1'b1, 1'b0), 0);
    endtask

    // Wake phase with given enables; defer_sleep raises a sleep request mid-restore.
    task automatic do_wake(input string tag, input bit rest, input bit ldo,
                           input bit defer_sleep);
        int busy_n = 0;
        int rf_w = 0;
        int cyc = 0;
        logic [TRIM_W-1:0] exp_trim;
        exp_trim = ldo ? otp_val : ldo_reg;
        @(negedge clk);
        restore_en   = rest;
        ldo_load_en  = ldo;
        host_gen_req = 1'b1;
        wake_evt     = 1'b1;
        @(negedge clk) wake_evt = 1'b0;
        while (!wake_done) begin
            if (busy) busy_n++;
            if (rf_wr_en) rf_w++;
            sleep_req = (defer_sleep && cyc == 3);
            cyc++;
            @(negedge clk);
        end
        sleep_req = 1'b0;
        check_eq("R4", {tag, " wake busy cycles"}, busy_n,
                 (rest ? COPY_CYCLES : 0) + (ldo ? 1 : 0));
        check_eq(rest ? "R4" : "R5", {tag, " register-file writes"}, rf_w,
                 rest ? NUM_WORDS : 0);
        check_eq(rest ? "R4" : "R5", {tag, " register-file mismatches"},
                 count_mismatch(1'b0, !rest), 0);
        check_eq(ldo ? "R6" : "R7", {tag, " trim register"}, ldo_reg, exp_trim);
        check_eq("R8", {tag, " held request granted at end"}, host_gen_gnt, 1);
        @(negedge clk);
        check_eq("R11", {tag, " done is one cycle"}, wake_done, 0);
        host_gen_req = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_a0c1));
        for (int i = 0; i < NUM_WORDS; i++) begin
            rf_mem[i]  = '0;
            ret_mem[i] = '0;
            snap[i]    = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset.
        check_eq("R1", "busy after reset", busy, 0);
        check_eq("R1", "asleep after reset", asleep, 0);
        check_eq("R1", "wake_done after reset", wake_done, 0);
        check_eq("R1", "write enables after reset", rf_wr_en | ret_wr_en | ldo_wr_en, 0);

        // Directed enable combinations with zeros, ones and random words.
        for (int it = 0; it < 10; it++) begin
            bit rest;
            bit ldo;
            int mode;
            mode = (it < 2) ? it : 2;
            case (it)
                0: begin rest = 1'b1; ldo = 1'b1; end
                1: begin rest = 1'b1; ldo = 1'b0; end
                2: begin rest = 1'b0; ldo = 1'b1; end
                3: begin rest = 1'b0; ldo = 1'b0; end
                default: begin rest = 1'($urandom % 2); ldo = 1'($urandom % 2); end
            endcase
            otp_val = TRIM_W'($urandom | 1);
            load_rf(mode, 1'b0);
            do_save($sformatf("iter%0d", it));
            // R3: clobber the register file while asleep; retention must stay.
            load_rf(mode, 1'b1);
            check_eq("R3", "retention kept while asleep", count_mismatch(1'b1, 1'b0), 0);
            do_wake($sformatf("iter%0d", it), rest, ldo, 1'b0);
        end

        // R10: sleep request during restore is deferred and replayed.
        otp_val = 8'h5a;
        load_rf(2, 1'b0);
        do_save("defer");
        load_rf(2, 1'b1);
        do_wake("defer", 1'b1, 1'b1, 1'b1);
        check_eq("R10", "save started after wake_done", busy, 1);
        begin
            int busy_n = 1;
            @(negedge clk);
            while (!asleep) begin
                if (busy) busy_n++;
                @(negedge clk);
            end
            check_eq("R10", "deferred save busy cycles", busy_n, COPY_CYCLES);
            check_eq("R10", "deferred save contents", count_mismatch(1'b1, 1'b0), 0);
        end
        do_wake("final", 1'b1, 1'b0, 1'b0);

        check_eq("R8", "grants while busy", viol_gnt, 0);
        check_eq("R9", "buffer grant mismatches", viol_buf, 0);
        finish_run();
    end

endmodule